// File: doc/BRIEF.md
# Slot Access Timeout Guard

This block sits between a host-side bus bridge and a peripheral slot and watches every slot access. When an access begins it starts counting clock cycles. If the slot acknowledges in time, the block passes a completion to the host together with the slot's read data. If the slot stays silent for the full timeout, the block ends the cycle itself, so the host bus never hangs. It signals a normal acknowledge toward the host and returns all-ones data for a read. A write that times out is simply lost and is not retried.

Timeout detection cannot be switched off; no input disables it. A timed-out access is visible to the rest of the chip only through a one-clock bus-error event pulse. A separate status and interrupt block consumes this pulse. The timeout length is the parameter `TIMEOUT_CYCLES`. Set it to roughly 7.6 microseconds of the clock in use, for example 243 at 32 MHz. Only one access is tracked at a time. After any completion, real or substituted, the block returns to idle, and the next access is timed from zero.

Top module: `slot_cycle_guard`

## Requirements
- R1: After reset, `host_ack` and `berr_pulse` are 0, `host_rdata` is all zeros, and the block is idle.
- R2: If `slot_ack` is sampled high on clock edge n after the start edge, with 1 <= n <= `TIMEOUT_CYCLES`, then `host_ack` is high for exactly the cycle after edge n and `berr_pulse` stays 0. For a read, `host_rdata` then equals the `slot_rdata` sampled on edge n.
- R3: If no acknowledge arrives, then `host_ack` and `berr_pulse` are both high for exactly the one cycle that follows the clock edge `TIMEOUT_CYCLES` edges after the edge that sampled `cyc_start`. This detection is always active.
- R4: A timed-out read returns `host_rdata` with every bit 1 (0xFFFF at 16 bits).
- R5: A completed write, whether acknowledged or timed out, leaves `host_rdata` unchanged. A timed-out write is not retried.
- R6: An acknowledge sampled on the same edge as expiry (edge `TIMEOUT_CYCLES`) wins. The access completes as in R2, with no bus error.
- R7: `berr_pulse` is never high for two consecutive cycles, even when a new access starts on the edge right after a timeout.
- R8: After a timeout the block is idle, and a new access gets the full `TIMEOUT_CYCLES` window measured from its own start edge.
- R9: `cyc_start` while an access is pending has no effect. `slot_ack` while idle, including a late acknowledge after a timeout, produces no `host_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Start of a slot access; honoured only while idle |
| cyc_write | input | 1 | 1 = write, 0 = read; sampled with `cyc_start` |
| slot_ack | input | 1 | Acknowledge from the slot |
| slot_rdata | input | DATA_W | Read data from the slot, valid with `slot_ack` |
| host_ack | output | 1 | Completion toward the host, real or substituted |
| host_rdata | output | DATA_W | Read data for the host, updated on read completions |
| berr_pulse | output | 1 | One-cycle bus-error event on a timeout |

## Verification
The hardest case to reach from the ports is the race on the last edge of the window: an acknowledge arriving on exactly the edge where the count expires. A second hard case is a new access starting on the very edge after a timeout, while the error pulse is still high. The bench uses a small timeout and a driver that places `slot_ack` on a chosen edge index counted from the start edge. This lets it put the acknowledge on edge `TIMEOUT_CYCLES`, on the edge after it, or nowhere. The driver also issues accesses back to back with no idle gap, which exposes both the pulse-width rule and the restart of the window.

// File: rtl/slot_guard_pkg.sv
package slot_guard_pkg;

  typedef enum logic {
    SG_IDLE = 1'b0,
    SG_WAIT = 1'b1
  } sg_state_e;

  // Width of a counter that must hold values 0 .. t
  function automatic int unsigned sg_cnt_width(input int unsigned t);
    int unsigned w;
    w = $clog2(t + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Index of the final waiting cycle, counted from zero
  function automatic int unsigned sg_last_index(input int unsigned t);
    return (t < 1) ? 0 : t - 1;
  endfunction

endpackage

// File: rtl/sg_timeout_timer.sv
module sg_timeout_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 243
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  import slot_guard_pkg::*;

  localparam int unsigned CNT_W = sg_cnt_width(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(sg_last_index(TIMEOUT_CYCLES));

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);

  // The count never runs past the final waiting cycle (window bound, R3)
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/sg_cycle_ctrl.sv
module sg_cycle_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_write,
  input  logic slot_ack,
  input  logic expired,
  output logic busy,
  output logic start_ev,
  output logic real_done,
  output logic timeout_ev,
  output logic is_write
);
  import slot_guard_pkg::*;

  sg_state_e state_q, state_d;
  logic      wr_q;

  assign busy       = (state_q == SG_WAIT);
  assign start_ev   = !busy && cyc_start;
  assign real_done  = busy && slot_ack;
  assign timeout_ev = busy && !slot_ack && expired;
  assign is_write   = wr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SG_IDLE: if (cyc_start)                 state_d = SG_WAIT;
      SG_WAIT: if (real_done || timeout_ev)   state_d = SG_IDLE;
      default:                                state_d = SG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SG_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ev) wr_q <= cyc_write;
    end
  end

  // A pending access stays pending when another start arrives (R9)
  assert_restart_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc_start && !slot_ack && !expired) |=> busy);

  // Expiry always releases the block to idle (R8)
  assert_timeout_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev |=> !busy);

  // Direction is frozen for the whole pending access (R5)
  assert_dir_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wr_q));

endmodule

// File: rtl/sg_resp_path.sv
module sg_resp_path #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              real_done,
  input  logic              timeout_ev,
  input  logic              is_write,
  input  logic [DATA_W-1:0] slot_rdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic              berr_pulse
);

  function automatic logic [DATA_W-1:0] idle_bus_value();
    return {DATA_W{1'b1}};
  endfunction

  function automatic logic [DATA_W-1:0] pick_rdata(
    input logic              timed_out,
    input logic [DATA_W-1:0] slot_val
  );
    return timed_out ? idle_bus_value() : slot_val;
  endfunction

  logic done;
  assign done = real_done || timeout_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_ack   <= 1'b0;
      berr_pulse <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack   <= done;
      berr_pulse <= timeout_ev;
      if (done && !is_write) host_rdata <= pick_rdata(timeout_ev, slot_rdata);
    end
  end

  // Error event is one clock wide (R7)
  assert_berr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    berr_pulse |=> !berr_pulse);

  // A substituted completion still acknowledges the host (R3)
  assert_berr_acks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    berr_pulse |-> host_ack);

  // Timed-out read returns all ones (R4)
  assert_timeout_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_ev && !is_write) |=> (host_rdata == idle_bus_value()));

  // Write completions leave the read data alone (R5)
  assert_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_write) |=> $stable(host_rdata));

  // A real acknowledge never raises a bus error (R6)
  assert_real_no_berr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    real_done |=> !berr_pulse);

endmodule

// File: rtl/slot_cycle_guard.sv
module slot_cycle_guard #(
  parameter int unsigned TIMEOUT_CYCLES = 243,
  parameter int unsigned DATA_W         = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cyc_write,
  input  logic              slot_ack,
  input  logic [DATA_W-1:0] slot_rdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic              berr_pulse
);

  logic busy_w, start_w, real_done_w, timeout_w, is_write_w, expired_w;
  logic timer_clear_w;

  assign timer_clear_w = start_w || real_done_w || timeout_w;

  sg_timeout_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (timer_clear_w),
    .run     (busy_w),
    .expired (expired_w)
  );

  sg_cycle_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .cyc_write  (cyc_write),
    .slot_ack   (slot_ack),
    .expired    (expired_w),
    .busy       (busy_w),
    .start_ev   (start_w),
    .real_done  (real_done_w),
    .timeout_ev (timeout_w),
    .is_write   (is_write_w)
  );

  sg_resp_path #(.DATA_W(DATA_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .real_done  (real_done_w),
    .timeout_ev (timeout_w),
    .is_write   (is_write_w),
    .slot_rdata (slot_rdata),
    .host_ack   (host_ack),
    .host_rdata (host_rdata),
    .berr_pulse (berr_pulse)
  );

  // No completion can follow a cycle spent idle (R9)
  assert_idle_ack_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |=> !host_ack);

  // A fresh access never expires on its first waiting edge unless the window is one cycle (R8)
  assert_fresh_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && (TIMEOUT_CYCLES > 1)) |=> !expired_w);

endmodule

// File: tb/slot_cycle_guard_tb_top.sv
`timescale 1ns/100ps
module slot_cycle_guard_tb_top;

  localparam int unsigned T  = 12;
  localparam int unsigned DW = 16;

  typedef struct {
    int          cyc;
    bit          berr;
    logic [DW-1:0] rd;
    string       req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc_start = 1'b0;
  logic          cyc_write = 1'b0;
  logic          slot_ack = 1'b0;
  logic [DW-1:0] slot_rdata = '0;
  logic          host_ack;
  logic [DW-1:0] host_rdata;
  logic          berr_pulse;

  int checks = 0;
  int errors = 0;
  int cycle_cnt = 0;
  bit finished = 1'b0;
  logic [DW-1:0] last_rd = '0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cycle_cnt <= cycle_cnt + 1;

  slot_cycle_guard #(.TIMEOUT_CYCLES(T), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_write(cyc_write),
    .slot_ack(slot_ack), .slot_rdata(slot_rdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .berr_pulse(berr_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: ack_at = edge index (from start edge) of slot_ack; 0 = never.
  // restart_at = edge index at which a second cyc_start is driven (0 = none).
  task automatic access(input bit wr, input int ack_at, input logic [DW-1:0] d,
                        input int restart_at, input string req);
    exp_t e;
    int   done_at;
    int   last_k;
    done_at = (ack_at >= 1 && ack_at <= int'(T)) ? ack_at : int'(T);
    e.cyc  = cycle_cnt + 1 + done_at;
    e.berr = !(ack_at >= 1 && ack_at <= int'(T));
    if (wr)          e.rd = last_rd;
    else if (e.berr) e.rd = '1;
    else             e.rd = d;
    last_rd = e.rd;
    e.req = req;
    q.push_back(e);
    cyc_start = 1'b1;
    cyc_write = wr;
    @(negedge clk);
    cyc_start = 1'b0;
    cyc_write = 1'b0;
    last_k = (ack_at > done_at) ? ack_at : done_at;
    for (int k = 1; k <= last_k; k++) begin
      if (k == ack_at) begin slot_ack = 1'b1; slot_rdata = d; end
      if (k == restart_at) begin cyc_start = 1'b1; cyc_write = ~wr; end
      @(negedge clk);
      slot_ack   = 1'b0;
      slot_rdata = 16'h5A5A;
      cyc_start  = 1'b0;
      cyc_write  = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  bit prev_berr = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_berr && berr_pulse)
          chk(1'b0, "R7", "berr_pulse two cycles", DW'(berr_pulse), '0);
        if (q.size() > 0 && cycle_cnt == q[0].cyc) begin
          exp_t e;
          e = q.pop_front();
          chk(host_ack == 1'b1, e.req, "host_ack", DW'(host_ack), DW'(1));
          chk(berr_pulse == e.berr, e.req, "berr_pulse", DW'(berr_pulse), DW'(e.berr));
          chk(host_rdata == e.rd, e.req, "host_rdata", host_rdata, e.rd);
        end else begin
          if (host_ack) chk(1'b0, "R9", "unexpected host_ack", DW'(host_ack), '0);
          if (berr_pulse) chk(1'b0, "R3", "unexpected berr_pulse", DW'(berr_pulse), '0);
        end
        prev_berr = berr_pulse;
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      chk(1'b0, "WDOG", "watchdog expired", '0, '1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(host_ack == 1'b0, "R1", "host_ack after reset", DW'(host_ack), '0);
    chk(berr_pulse == 1'b0, "R1", "berr after reset", DW'(berr_pulse), '0);
    chk(host_rdata == '0, "R1", "host_rdata after reset", host_rdata, '0);

    access(1'b0, 3, 16'hA5A5, 0, "R2");      // read, early ack
    access(1'b1, 1, 16'h1111, 0, "R2_R5");   // write, ack on first edge, data held
    access(1'b0, 0, 16'h0000, 0, "R3_R4");   // read timeout -> all ones
    access(1'b0, 5, 16'h1234, 0, "R2");      // read, new data
    access(1'b1, 0, 16'h0000, 0, "R3_R5");   // write timeout, data held
    access(1'b0, int'(T), 16'h0BCD, 0, "R6");// ack on expiry edge wins
    access(1'b0, 0, 16'h0000, 0, "R3_R7");   // timeout followed at once by
    access(1'b0, 2, 16'h7E57, 0, "R7");      // a new access
    access(1'b1, 0, 16'h0000, 0, "R8");      // timeout back to back
    access(1'b0, 0, 16'h0000, 0, "R8");      // full window again
    access(1'b0, int'(T) + 1, 16'hBEEF, 0, "R9"); // late ack ignored
    access(1'b0, 6, 16'h2468, 3, "R9");      // start while busy ignored
    access(1'b0, 0, 16'h0000, 4, "R9");      // restart does not extend window
    // slot_ack while idle
    repeat (3) begin slot_ack = 1'b1; slot_rdata = 16'hDEAD; @(negedge clk); end
    slot_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(host_rdata == last_rd, "R9", "idle ack left host_rdata", host_rdata, last_rd);
    chk(q.size() == 0, "R2", "all completions observed", DW'(q.size()), '0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule